// File: doc/BRIEF.md
# Capture/Reload Timer with Up-Down Counting

A 16-bit timer/counter with one 16-bit companion register that is used either as a capture latch or as a reload value. The count advances once per machine-cycle strobe (`tick_en`) in timer mode, or once per falling edge of the external count pin in counter mode. Both pins are sampled only on machine-cycle strobes. An external trigger pin is sampled in the same way.

Three modes share this datapath:
- **Capture mode.** The block is a plain wrap-around up-counter. When the external enable is set, it also latches its count on a trigger falling edge.
- **Reload mode.** The count reloads from the companion register on overflow, and also on a trigger edge when the external enable is set. This mode can count down instead of up.
- **Baud mode.** The block is an up-counting reload timer whose overflows are sent as one-cycle pulses to a serial receiver and/or transmitter. These overflows do not set the overflow flag.

Software reaches the block through a byte-wide register port. Writes are synchronous and reads are combinational. There are two sticky flags, overflow and external, and each is cleared by writing a one to its bit.

Top module: `cr_timer`

## Requirements
- R1: After reset every register reads 0x00, both flags are low and both baud pulse outputs are low.
- R2: Register byte addresses: 0 control, 1 status, 2 count low, 3 count high, 4 companion low, 5 companion high. Every register reads back what was last written; all eight control bits are stored. Control bits: 0 run, 1 count-pin source, 2 capture mode, 3 external enable, 4 down enable, 5 receive baud select, 6 transmit baud select. Status: bit 0 overflow flag, bit 1 external flag.
- R3: With run set and source clear, the count advances by one on each `tick_en` cycle. With source set, it advances by one on each count-pin falling edge. With run clear, it holds.
- R4: In capture mode with external enable clear, the count wraps 0xFFFF to 0x0000 and sets the overflow flag. Trigger edges change neither the companion register nor the external flag.
- R5: In capture mode with external enable set, a trigger falling edge copies the count from before that tick into the companion register and sets the external flag. The count keeps running.
- R6: In reload mode counting up, a step at 0xFFFF loads the companion value and sets the overflow flag.
- R7: In reload mode with external enable set, a trigger falling edge loads the companion value into the count and sets the external flag.
- R8: In reload mode with down enable set, each step decrements the count. A step taken while the count equals the companion value loads 0xFFFF instead and sets the overflow flag.
- R9: In baud mode (either baud select set), the block counts up and reloads from the companion register on overflow, ignoring the capture and down bits. Each overflow gives a one-cycle pulse, in the following cycle, on the output of each select that is set. The overflow flag is not set.
- R10: In baud mode with external enable set, a trigger falling edge sets the external flag without reloading the count.
- R11: Flags stay set until a status write with a one in the flag's bit. A zero in that bit leaves the flag unchanged.
- R12: The count and trigger pins are sampled only on `tick_en` cycles. A falling edge is a high sample followed by a low sample, and a pin pulse that falls between two ticks is not seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Machine-cycle strobe |
| cnt_in | input | 1 | External count pin |
| trig_in | input | 1 | External trigger pin |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| ovf_flag | output | 1 | Sticky overflow flag |
| ext_flag | output | 1 | Sticky external-trigger flag |
| rx_baud_pulse | output | 1 | Receiver baud clock pulse |
| tx_baud_pulse | output | 1 | Transmitter baud clock pulse |

## Verification
The assertions on count and companion progress assume that no software write to those bytes lands in the same cycle as the hardware update. Their antecedents exclude such cycles, and the stimulus only writes registers while `tick_en` is low. The sticky-flag and baud-pulse checks assume the control register is stable across the cycle that produced the event. The pins change only on falling clock edges and only while no tick is pending, so each sampled level is unambiguous. Every scenario stops the timer before it reloads the count and companion registers, so the writes never race a running count.

// File: rtl/crt_pkg.sv
// Shared types and register layout for the capture/reload timer.
// Assumes a byte-wide register port; the counter width is a multiple of it.
package crt_pkg;

    // Functional control bits; the packed order fixes their positions (run = bit 0).
    typedef struct packed {
        logic tx_sel;
        logic rx_sel;
        logic down_en;
        logic ext_en;
        logic cap_mode;
        logic src_ext;
        logic run;
    } crt_ctrl_t;

    localparam int CTRL_BITS = $bits(crt_ctrl_t);
    localparam int ADDR_CTRL = 0;
    localparam int ADDR_STAT = 1;
    localparam int ADDR_CNT  = 2;
    localparam int STAT_OVF  = 0;
    localparam int STAT_EXT  = 1;

endpackage

// File: rtl/crt_sampler.sv
// Pin sampler: captures each external pin once per machine cycle and reports
// a falling edge (high sample then low sample) in the tick cycle that sees it.
// Assumes pins are already synchronous to clk.
module crt_sampler #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    input  logic [N-1:0] pin,
    output logic [N-1:0] fall
);

    logic [N-1:0] last_q;

    // Hold the level seen at the previous machine-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= '0;
        end else if (tick_en) begin
            last_q <= pin;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_pin
        // Edge is only valid on a strobe, comparing against the stored sample.
        assign fall[i] = tick_en && last_q[i] && !pin[i];
    end

endmodule

// File: rtl/crt_core.sv
// Counting datapath: the running count and its companion register.
// Chooses the next count from step, trigger and mode; byte-lane software
// writes take priority over hardware updates in the same cycle.
module crt_core #(
    parameter  int W  = 16,
    parameter  int DW = 8,
    localparam int NB = W / DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          trig_fall,
    input  logic          cap_mode,
    input  logic          ext_en,
    input  logic          down_en,
    input  logic          baud,
    input  logic [NB-1:0] cnt_we,
    input  logic [NB-1:0] crr_we,
    input  logic [DW-1:0] wr_data,
    output logic [W-1:0]  cnt_q,
    output logic [W-1:0]  crr_q,
    output logic          ovf_set,
    output logic          ext_set,
    output logic          baud_ovf
);

    logic         down_mode, reload_mode, trig_reload, trig_capture;
    logic         up_wrap, down_wrap;
    logic [W-1:0] cnt_n, crr_n, cnt_d, crr_d;

    // Mode decode and next-state selection for count and companion.
    always_comb begin
        down_mode    = down_en && !cap_mode && !baud;
        reload_mode  = baud || !cap_mode;
        trig_reload  = ext_en && trig_fall && !cap_mode && !baud;
        trig_capture = ext_en && trig_fall && cap_mode && !baud;
        up_wrap      = step && !down_mode && (cnt_q == '1);
        down_wrap    = step && down_mode && (cnt_q == crr_q);

        cnt_n = cnt_q;
        if (trig_reload) begin
            cnt_n = crr_q;
        end else if (up_wrap) begin
            cnt_n = reload_mode ? crr_q : '0;
        end else if (down_wrap) begin
            cnt_n = '1;
        end else if (step) begin
            cnt_n = down_mode ? cnt_q - W'(1) : cnt_q + W'(1);
        end
        crr_n = trig_capture ? cnt_q : crr_q;

        ovf_set  = !baud && (up_wrap || down_wrap);
        baud_ovf = baud && up_wrap;
        ext_set  = ext_en && trig_fall;
    end

    // Merge software byte writes over the hardware result, lane by lane.
    always_comb begin
        for (int b = 0; b < NB; b++) begin
            cnt_d[b*DW +: DW] = cnt_we[b] ? wr_data : cnt_n[b*DW +: DW];
            crr_d[b*DW +: DW] = crr_we[b] ? wr_data : crr_n[b*DW +: DW];
        end
    end

    // State update for count and companion register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            crr_q <= '0;
        end else begin
            cnt_q <= cnt_d;
            crr_q <= crr_d;
        end
    end

    AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !trig_reload && !(|cnt_we)) |=> $stable(cnt_q)); // R3
    AST_CAPTURE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_capture && !(|crr_we)) |=> (crr_q == $past(cnt_q))); // R5
    AST_UP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (step && reload_mode && !down_mode && (cnt_q == '1) && !trig_reload && !(|cnt_we))
        |=> (cnt_q == $past(crr_q))); // R6
    AST_DOWN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && down_mode && (cnt_q == crr_q) && !trig_reload && !(|cnt_we))
        |=> (cnt_q == '1)); // R8

endmodule

// File: rtl/crt_regs.sv
// Register port and flags: write decode, control storage, sticky flags with
// write-one-to-clear, baud pulse registers and the combinational read mux.
// Assumes the companion and count byte lanes follow the status address.
module crt_regs
    import crt_pkg::*;
#(
    parameter  int W  = 16,
    parameter  int DW = 8,
    localparam int NB = W / DW,
    localparam int AW = $clog2(ADDR_CNT + 2 * NB)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic [W-1:0]  cnt_q,
    input  logic [W-1:0]  crr_q,
    input  logic          ovf_set,
    input  logic          ext_set,
    input  logic          baud_ovf,
    output crt_ctrl_t     ctrl,
    output logic [NB-1:0] cnt_we,
    output logic [NB-1:0] crr_we,
    output logic          ovf_flag,
    output logic          ext_flag,
    output logic          rx_pulse,
    output logic          tx_pulse
);

    localparam int CRR_BASE = ADDR_CNT + NB;

    logic [DW-1:0] ctrl_raw;
    logic          stat_wr, ovf_clr, ext_clr, baud;

    assign ctrl    = crt_ctrl_t'(ctrl_raw[CTRL_BITS-1:0]);
    assign baud    = ctrl.rx_sel || ctrl.tx_sel;
    assign stat_wr = wr_en && (wr_addr == AW'(ADDR_STAT));
    assign ovf_clr = stat_wr && wr_data[STAT_OVF];
    assign ext_clr = stat_wr && wr_data[STAT_EXT];

    for (genvar b = 0; b < NB; b++) begin : g_we
        // One write strobe per byte lane of count and companion.
        assign cnt_we[b] = wr_en && (wr_addr == AW'(ADDR_CNT + b));
        assign crr_we[b] = wr_en && (wr_addr == AW'(CRR_BASE + b));
    end

    // Control register storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_raw <= '0;
        end else if (wr_en && (wr_addr == AW'(ADDR_CTRL))) begin
            ctrl_raw <= wr_data;
        end
    end

    // Sticky flags: a hardware set beats a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_flag <= 1'b0;
            ext_flag <= 1'b0;
        end else begin
            if (ovf_set)      ovf_flag <= 1'b1;
            else if (ovf_clr) ovf_flag <= 1'b0;
            if (ext_set)      ext_flag <= 1'b1;
            else if (ext_clr) ext_flag <= 1'b0;
        end
    end

    // One-cycle baud pulses, steered by the select bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_pulse <= 1'b0;
            tx_pulse <= 1'b0;
        end else begin
            rx_pulse <= baud_ovf && ctrl.rx_sel;
            tx_pulse <= baud_ovf && ctrl.tx_sel;
        end
    end

    // Combinational read mux over all addresses.
    always_comb begin
        rd_data = '0;
        if (rd_addr == AW'(ADDR_CTRL)) rd_data = ctrl_raw;
        if (rd_addr == AW'(ADDR_STAT)) rd_data = DW'({ext_flag, ovf_flag});
        for (int b = 0; b < NB; b++) begin
            if (rd_addr == AW'(ADDR_CNT + b)) rd_data = cnt_q[b*DW +: DW];
            if (rd_addr == AW'(CRR_BASE + b)) rd_data = crr_q[b*DW +: DW];
        end
    end

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag); // R11
    AST_EXT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_flag && !ext_clr) |=> ext_flag); // R11
    AST_NO_OVF_IN_BAUD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> !$past(baud)); // R9
    AST_RX_PULSE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pulse |-> $past(ctrl.rx_sel)); // R9
    AST_TX_PULSE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pulse |-> $past(ctrl.tx_sel)); // R9

endmodule

// File: rtl/cr_timer.sv
// Top of the capture/reload timer. Joins the pin sampler, the counting
// datapath and the register block, and forms the count step from the run
// and source controls. Assumes tick_en is a one-cycle machine-cycle strobe.
module cr_timer
    import crt_pkg::*;
#(
    parameter  int W  = 16,
    parameter  int DW = 8,
    localparam int NB = W / DW,
    localparam int AW = $clog2(ADDR_CNT + 2 * NB)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          cnt_in,
    input  logic          trig_in,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          ovf_flag,
    output logic          ext_flag,
    output logic          rx_baud_pulse,
    output logic          tx_baud_pulse
);

    crt_ctrl_t     ctrl;
    logic [1:0]    fall;
    logic          step, baud;
    logic [NB-1:0] cnt_we, crr_we;
    logic [W-1:0]  cnt_q, crr_q;
    logic          ovf_set, ext_set, baud_ovf;

    crt_sampler #(.N(2)) i_sampler (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .pin     ({trig_in, cnt_in}),
        .fall    (fall)
    );

    // Count step: machine cycles in timer mode, pin edges in counter mode.
    assign step = ctrl.run && (ctrl.src_ext ? fall[0] : tick_en);
    assign baud = ctrl.rx_sel || ctrl.tx_sel;

    crt_core #(.W(W), .DW(DW)) i_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .trig_fall (fall[1]),
        .cap_mode  (ctrl.cap_mode),
        .ext_en    (ctrl.ext_en),
        .down_en   (ctrl.down_en),
        .baud      (baud),
        .cnt_we    (cnt_we),
        .crr_we    (crr_we),
        .wr_data   (wr_data),
        .cnt_q     (cnt_q),
        .crr_q     (crr_q),
        .ovf_set   (ovf_set),
        .ext_set   (ext_set),
        .baud_ovf  (baud_ovf)
    );

    crt_regs #(.W(W), .DW(DW)) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .cnt_q    (cnt_q),
        .crr_q    (crr_q),
        .ovf_set  (ovf_set),
        .ext_set  (ext_set),
        .baud_ovf (baud_ovf),
        .ctrl     (ctrl),
        .cnt_we   (cnt_we),
        .crr_we   (crr_we),
        .ovf_flag (ovf_flag),
        .ext_flag (ext_flag),
        .rx_pulse (rx_baud_pulse),
        .tx_pulse (tx_baud_pulse)
    );

endmodule

// File: tb/test_cr_timer.sv
`timescale 1ns/1ps
module test_cr_timer;

    localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_CNT = 3'd2, A_CRR = 3'd4;
    localparam logic [7:0] C_RUN = 8'h01, C_SRC = 8'h02, C_CAP = 8'h04, C_EXT = 8'h08,
                           C_DOWN = 8'h10, C_RX = 8'h20, C_TX = 8'h40;

    logic       clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, cnt_in = 1'b0, trig_in = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0, rd_addr = '0;
    logic [7:0] wr_data = '0, rd_data;
    logic       ovf_flag, ext_flag, rx_baud_pulse, tx_baud_pulse;
    int         n_tests = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    cr_timer i_cr_timer (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt_in(cnt_in), .trig_in(trig_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .ovf_flag(ovf_flag), .ext_flag(ext_flag),
        .rx_baud_pulse(rx_baud_pulse), .tx_baud_pulse(tx_baud_pulse)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        rd_addr = a; #0.5; v = int'(rd_data);
    endtask

    task automatic rd16(input logic [2:0] a, output int v);
        int lo, hi;
        rd(a, lo); rd(a + 3'd1, hi); v = (hi << 8) | lo;
    endtask

    task automatic wr16(input logic [2:0] a, input logic [15:0] v);
        wr(a, v[7:0]); wr(a + 3'd1, v[15:8]);
    endtask

    task automatic ticks(input int n);
        @(negedge clk); tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic setup(input logic [15:0] cnt, input logic [15:0] crr, input logic [7:0] c);
        wr(A_CTRL, 8'h00); wr(A_STAT, 8'h03);
        wr16(A_CNT, cnt); wr16(A_CRR, crr); wr(A_CTRL, c);
    endtask

    task automatic trig_edge();
        trig_in = 1'b1; ticks(1); trig_in = 1'b0; ticks(1);
    endtask

    task automatic t_reset();
        int v;
        for (int a = 0; a < 6; a++) begin rd(3'(a), v); check("R1 register", v, 0); end
        check("R1 flags", {ovf_flag, ext_flag}, 0);
        check("R1 pulses", {rx_baud_pulse, tx_baud_pulse}, 0);
    endtask

    task automatic t_regs();
        int v;
        wr16(A_CNT, 16'h1234); wr16(A_CRR, 16'hABCD); wr(A_CTRL, 8'h80);
        rd16(A_CNT, v); check("R2 count", v, 'h1234);
        rd16(A_CRR, v); check("R2 companion", v, 'hABCD);
        rd(A_CTRL, v); check("R2 control", v, 'h80);
        wr(A_CTRL, 8'h00);
    endtask

    task automatic t_run_source();
        int v;
        setup(16'h0010, 16'h0000, C_RUN | C_CAP);
        ticks(5); rd16(A_CNT, v); check("R3 timer steps", v, 'h0015);
        wr(A_CTRL, C_CAP); ticks(3); rd16(A_CNT, v); check("R3 run clear holds", v, 'h0015);
        setup(16'h0000, 16'h0000, C_RUN | C_SRC | C_CAP);
        cnt_in = 1'b1; ticks(1); cnt_in = 1'b0; ticks(1);
        cnt_in = 1'b1; ticks(1); cnt_in = 1'b0; ticks(1);
        rd16(A_CNT, v); check("R3 pin edges counted", v, 2);
        cnt_in = 1'b1; repeat (2) @(negedge clk); cnt_in = 1'b0; ticks(1);
        rd16(A_CNT, v); check("R12 pulse between ticks unseen", v, 2);
        ticks(3); rd16(A_CNT, v); check("R12 steady low no edge", v, 2);
    endtask

    task automatic t_plain_wrap();
        int v;
        setup(16'hFFFE, 16'h5555, C_RUN | C_CAP);
        ticks(3); rd16(A_CNT, v); check("R4 wrap to zero", v, 1);
        check("R4 overflow flag", ovf_flag, 1);
        trig_edge(); rd16(A_CRR, v); check("R4 trigger ignored companion", v, 'h5555);
        check("R4 trigger ignored flag", ext_flag, 0);
        rd16(A_CNT, v); check("R4 keeps counting", v, 3);
        wr(A_STAT, 8'h02); check("R11 zero bit keeps flag", ovf_flag, 1);
        wr(A_STAT, 8'h01); check("R11 one bit clears flag", ovf_flag, 0);
    endtask

    task automatic t_capture();
        int v;
        setup(16'h0100, 16'h0000, C_RUN | C_CAP | C_EXT);
        trig_edge();
        rd16(A_CRR, v); check("R5 captured count", v, 'h0101);
        rd16(A_CNT, v); check("R5 count continues", v, 'h0102);
        check("R5 ext flag", ext_flag, 1);
        ticks(2); check("R11 ext flag held", ext_flag, 1);
    endtask

    task automatic t_reload_up();
        int v;
        setup(16'hFFFE, 16'hFFF0, C_RUN);
        ticks(2); rd16(A_CNT, v); check("R6 reload on overflow", v, 'hFFF0);
        check("R6 overflow flag", ovf_flag, 1);
        ticks(1); rd16(A_CNT, v); check("R6 counts from reload", v, 'hFFF1);
    endtask

    task automatic t_trig_reload();
        int v;
        setup(16'h0050, 16'h0200, C_RUN | C_EXT);
        trig_edge(); rd16(A_CNT, v); check("R7 trigger reload", v, 'h0200);
        check("R7 ext flag", ext_flag, 1);
        check("R7 no overflow", ovf_flag, 0);
    endtask

    task automatic t_down();
        int v;
        setup(16'h0005, 16'h0003, C_RUN | C_DOWN);
        ticks(2); rd16(A_CNT, v); check("R8 decrement", v, 3);
        check("R8 no flag yet", ovf_flag, 0);
        ticks(1); rd16(A_CNT, v); check("R8 underflow loads top", v, 'hFFFF);
        check("R8 overflow flag", ovf_flag, 1);
        ticks(1); rd16(A_CNT, v); check("R8 decrement after wrap", v, 'hFFFE);
    endtask

    task automatic t_baud();
        int v;
        setup(16'hFFFE, 16'hFFFD, C_RUN | C_RX);
        ticks(2);
        check("R9 rx pulse", {rx_baud_pulse, tx_baud_pulse}, 2'b10);
        check("R9 no overflow flag", ovf_flag, 0);
        @(negedge clk); check("R9 pulse one cycle", rx_baud_pulse, 0);
        rd16(A_CNT, v); check("R9 reload", v, 'hFFFD);
        setup(16'hFFFF, 16'hFFFD, C_RUN | C_TX);
        ticks(1); check("R9 tx pulse", {rx_baud_pulse, tx_baud_pulse}, 2'b01);
        setup(16'hFFFF, 16'h1000, C_RUN | C_RX | C_DOWN | C_CAP);
        ticks(1); rd16(A_CNT, v); check("R9 down and capture ignored", v, 'h1000);
        check("R9 pulse with down bit", rx_baud_pulse, 1);
        setup(16'h0100, 16'h1000, C_RUN | C_RX | C_EXT);
        trig_edge(); check("R10 ext flag in baud", ext_flag, 1);
        rd16(A_CNT, v); check("R10 no trigger reload", v, 'h0102);
        check("R10 no overflow flag", ovf_flag, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_run_source();
        t_plain_wrap();
        t_capture();
        t_reload_up();
        t_trig_reload();
        t_down();
        t_baud();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule